// File: doc/BRIEF.md
# 8-bit ALU with Status Flag Register

This block is the arithmetic and logic datapath of a small accumulator-style processor core. A combinational unit takes an operation code, a register operand and a memory operand, and produces an 8-bit result and a write strobe in the same cycle. The carry-in comes from the block's own flag register. The processor status byte is held in a register inside the block. On each clock edge where the operation enable is high, the executed operation updates its own subset of the flags. The other flag bits keep their values.

The sequencer places the accumulator or index register on `reg_i` for two-operand operations (add, subtract, AND, compare, bit test). The value to be shifted, incremented, decremented or transferred goes on `mem_i`. Compare and bit test only adjust flags and never raise the write strobe. Decimal arithmetic, instruction fetch and memory traffic belong to other blocks.

Top module: `alu8_status`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the status register loads 0x20. Its bit layout from bit 7 down to bit 0 is N, V, U (always 1), B, D, I, Z, C. No operation ever changes bits 5, 4, 3 or 2.
- R2: Op code 0 (add with carry) produces result = (reg + mem + C) mod 256. C is set when the full sum exceeds 255. V is set when reg and mem share bit 7 and the result's bit 7 differs from it. N and Z follow the result.
- R3: Op code 1 (subtract with borrow) produces result = (reg + ~mem + C) mod 256. C is set when that sum exceeds 255, which means no borrow. V uses the R2 rule with ~mem in place of mem. N and Z follow the result.
- R4: Op code 2 (AND) produces result = reg & mem. N and Z follow the result. V and C are kept.
- R5: Op code 3 (shift right) produces result = mem >> 1 with a zero shifted into bit 7. C takes mem bit 0, N is cleared, and Z follows the result. V is kept.
- R6: Op code 4 (compare) sets C when reg >= mem (unsigned) and sets Z when they are equal. N takes bit 7 of (reg - mem) mod 256. V is kept and no result is written.
- R7: Op code 5 (bit test) sets Z when (reg & mem) is zero and copies mem bit 6 into V and mem bit 7 into N. C is kept and no result is written.
- R8: Op codes 6, 7 and 8 (increment, decrement, transfer) produce mem + 1, mem - 1 and mem respectively, all modulo 256. N and Z follow the result. V and C are kept.
- R9: Op code 9 sets C and op code 10 clears C. No other flag changes and no result is written.
- R10: Op codes 11 to 15 are no-operations: the write strobe stays low and the status is unchanged.
- R11: `wr_o` is high exactly when `en_i` is high and the op code is 0, 1, 2, 3, 6, 7 or 8. `result_o` reads 0 whenever `wr_o` is low.
- R12: The status changes only at a rising edge where `en_i` is high. With `en_i` low, the status holds and `wr_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Execute the operation this cycle; enables the flag update |
| op_i | input | 4 | Operation code (see R2 to R10) |
| reg_i | input | 8 | Accumulator or index operand |
| mem_i | input | 8 | Memory or single-source operand |
| result_o | output | 8 | Combinational result |
| wr_o | output | 1 | Result is to be written back |
| status_o | output | 8 | Registered status byte N V U B D I Z C |

## Verification
The bench targets signed overflow at the 0x7F/0x80 boundary, both when adding and when subtracting. A design that derived V from the raw operand instead of the inverted one would flip V on subtracts. Carry is checked at the wrap points: 0xFF + 1, 0x00 - 1 with and without borrow, and compare of equal and unequal values. An inverted borrow sense or a signed compare would show up as a wrong C. Increment of 0xFF and decrement of 0x00 are also checked, along with a shift of 0x01. A shift that kept N or dropped bit 0 into the wrong flag would fail these. Random sequences with the enable dropping check that the flags hold and that bits 5 to 2 never move; a design with an over-wide update mask would fail them.

// File: rtl/alu8_pkg.sv
// Package: shared operation codes, flag positions and reset value for the
// 8-bit ALU. Assumes an 8-bit status byte whose layout is fixed by the core.
package alu8_pkg;

    localparam int DW     = 8;
    localparam int FLAG_W = 8;

    // Flag bit positions inside the status byte.
    localparam int FB_N = 7;
    localparam int FB_V = 6;
    localparam int FB_U = 5;
    localparam int FB_B = 4;
    localparam int FB_D = 3;
    localparam int FB_I = 2;
    localparam int FB_Z = 1;
    localparam int FB_C = 0;

    localparam logic [FLAG_W-1:0] STATUS_RST = 8'h20;

    typedef enum logic [3:0] {
        OP_ADDC = 4'd0,
        OP_SUBB = 4'd1,
        OP_AND  = 4'd2,
        OP_SHR  = 4'd3,
        OP_CMP  = 4'd4,
        OP_TEST = 4'd5,
        OP_INC  = 4'd6,
        OP_DEC  = 4'd7,
        OP_MOV  = 4'd8,
        OP_SETC = 4'd9,
        OP_CLRC = 4'd10
    } alu_op_e;

    // Single-bit flag mask helper.
    function automatic logic [FLAG_W-1:0] fbit(input int pos);
        logic [FLAG_W-1:0] m;
        m = '0;
        m[pos] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/alu8_adder.sv
// Module: shared adder for add, subtract and compare.
// Computes a + (invert ? ~b : b) + cin and reports carry-out and signed
// overflow judged against the effective (possibly inverted) second operand.
// Assumes both operands are two's complement of width W.
module alu8_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         invert_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;
    logic [W:0]   full;

    // Select the effective second operand and form the wide sum.
    always_comb begin
        b_eff = invert_i ? ~b_i : b_i;
        full  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
    end

    assign sum_o  = full[W-1:0];
    assign cout_o = full[W];
    assign ovf_o  = (a_i[MSB] == b_eff[MSB]) && (full[MSB] != a_i[MSB]);

endmodule

// File: rtl/alu8_unary.sv
// Module: logic and single-operand datapath: AND, shift right, increment,
// decrement, transfer, and the AND term used by bit test.
// Assumes the caller selects which output is meaningful for the op.
module alu8_unary #(
    parameter int W = 8
) (
    input  logic [W-1:0] reg_i,
    input  logic [W-1:0] mem_i,
    output logic [W-1:0] and_o,
    output logic [W-1:0] shr_o,
    output logic [W-1:0] inc_o,
    output logic [W-1:0] dec_o,
    output logic         shr_out_bit_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // Compute all candidate results in parallel; wrap modulo 2**W.
    always_comb begin
        and_o         = reg_i & mem_i;
        shr_o         = {1'b0, mem_i[W-1:1]};
        shr_out_bit_o = mem_i[0];
        inc_o         = mem_i + ONE;
        dec_o         = mem_i - ONE;
    end

endmodule

// File: rtl/alu8_flagreg.sv
// Module: per-bit masked status register with synchronous active-low reset.
// A bit loads its next value only on an enabled edge with its mask bit set.
// Assumes mask and next value are stable around the rising edge.
module alu8_flagreg #(
    parameter int              W   = 8,
    parameter logic [W-1:0]    RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd_i,
    input  logic [W-1:0] mask_i,
    input  logic [W-1:0] nxt_i,
    output logic [W-1:0] q_o
);
    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        logic bit_q;

        // Hold, reset or load one status bit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bit_q <= RST[gi];
            else if (upd_i && mask_i[gi])
                bit_q <= nxt_i[gi];
        end

        assign q_o[gi] = bit_q;
    end

endmodule

// File: rtl/alu8_status.sv
// Module: top of the 8-bit ALU with its status register.
// Decodes the op code, steers the shared adder and the unary datapath,
// builds the flag update value and mask, and drives the write strobe.
// Assumes one operation per enabled cycle; the result is combinational and
// the status updates on the following rising edge.
module alu8_status
    import alu8_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [3:0]       op_i,
    input  logic [DW-1:0]    reg_i,
    input  logic [DW-1:0]    mem_i,
    output logic [DW-1:0]    result_o,
    output logic             wr_o,
    output logic [FLAG_W-1:0] status_o
);
    localparam int MSB = DW - 1;

    alu_op_e          op;
    logic             c_in;
    logic             add_inv;
    logic             add_cin;
    logic [DW-1:0]    add_sum;
    logic             add_cout;
    logic             add_ovf;
    logic [DW-1:0]    and_res, shr_res, inc_res, dec_res;
    logic             shr_bit;
    logic [DW-1:0]    res_raw;
    logic             writes;
    logic [FLAG_W-1:0] fl_nxt;
    logic [FLAG_W-1:0] fl_mask;

    assign op   = alu_op_e'(op_i);
    assign c_in = status_o[FB_C];

    // Steer the adder: invert for subtract and compare; compare forces cin.
    always_comb begin
        add_inv = (op == OP_SUBB) || (op == OP_CMP);
        add_cin = (op == OP_CMP) ? 1'b1 : c_in;
    end

    alu8_adder #(.W(DW)) u_adder (
        .a_i      (reg_i),
        .b_i      (mem_i),
        .invert_i (add_inv),
        .cin_i    (add_cin),
        .sum_o    (add_sum),
        .cout_o   (add_cout),
        .ovf_o    (add_ovf)
    );

    alu8_unary #(.W(DW)) u_unary (
        .reg_i         (reg_i),
        .mem_i         (mem_i),
        .and_o         (and_res),
        .shr_o         (shr_res),
        .inc_o         (inc_res),
        .dec_o         (dec_res),
        .shr_out_bit_o (shr_bit)
    );

    // Select the raw result and whether the op writes it back.
    always_comb begin
        res_raw = '0;
        writes  = 1'b0;
        unique case (op)
            OP_ADDC, OP_SUBB: begin res_raw = add_sum; writes = 1'b1; end
            OP_AND:           begin res_raw = and_res; writes = 1'b1; end
            OP_SHR:           begin res_raw = shr_res; writes = 1'b1; end
            OP_INC:           begin res_raw = inc_res; writes = 1'b1; end
            OP_DEC:           begin res_raw = dec_res; writes = 1'b1; end
            OP_MOV:           begin res_raw = mem_i;   writes = 1'b1; end
            default:          begin res_raw = '0;      writes = 1'b0; end
        endcase
    end

    // Build the next flag values and the mask of flags this op may touch.
    always_comb begin
        fl_nxt  = status_o;
        fl_mask = '0;
        unique case (op)
            OP_ADDC, OP_SUBB: begin
                fl_nxt[FB_N] = add_sum[MSB];
                fl_nxt[FB_V] = add_ovf;
                fl_nxt[FB_Z] = (add_sum == '0);
                fl_nxt[FB_C] = add_cout;
                fl_mask = fbit(FB_N) | fbit(FB_V) | fbit(FB_Z) | fbit(FB_C);
            end
            OP_SHR: begin
                fl_nxt[FB_N] = 1'b0;
                fl_nxt[FB_Z] = (shr_res == '0);
                fl_nxt[FB_C] = shr_bit;
                fl_mask = fbit(FB_N) | fbit(FB_Z) | fbit(FB_C);
            end
            OP_CMP: begin
                fl_nxt[FB_N] = add_sum[MSB];
                fl_nxt[FB_Z] = (add_sum == '0);
                fl_nxt[FB_C] = add_cout;
                fl_mask = fbit(FB_N) | fbit(FB_Z) | fbit(FB_C);
            end
            OP_TEST: begin
                fl_nxt[FB_N] = mem_i[MSB];
                fl_nxt[FB_V] = mem_i[MSB-1];
                fl_nxt[FB_Z] = (and_res == '0);
                fl_mask = fbit(FB_N) | fbit(FB_V) | fbit(FB_Z);
            end
            OP_AND, OP_INC, OP_DEC, OP_MOV: begin
                fl_nxt[FB_N] = res_raw[MSB];
                fl_nxt[FB_Z] = (res_raw == '0);
                fl_mask = fbit(FB_N) | fbit(FB_Z);
            end
            OP_SETC: begin
                fl_nxt[FB_C] = 1'b1;
                fl_mask = fbit(FB_C);
            end
            OP_CLRC: begin
                fl_nxt[FB_C] = 1'b0;
                fl_mask = fbit(FB_C);
            end
            default: begin
                fl_nxt  = status_o;
                fl_mask = '0;
            end
        endcase
    end

    alu8_flagreg #(.W(FLAG_W), .RST(STATUS_RST)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd_i  (en_i),
        .mask_i (fl_mask),
        .nxt_i  (fl_nxt),
        .q_o    (status_o)
    );

    assign wr_o     = en_i && writes;
    assign result_o = wr_o ? res_raw : '0;

endmodule

// File: rtl/alu8_status_sva.sv
// Checker: temporal properties of the ALU status register and write strobe,
// attached to every instance of the top module by the bind below.
module alu8_status_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       en_i,
    input logic [3:0] op_i,
    input logic [7:0] reg_i,
    input logic [7:0] mem_i,
    input logic [7:0] result_o,
    input logic       wr_o,
    input logic [7:0] status_o
);
    // R1: a reset edge leaves the status at its reset value.
    a_r1_reset_value: assert property (@(posedge clk)
        !rst_n |=> status_o == 8'h20);

    // R1: the fixed bits never move once out of reset.
    a_r1_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(status_o[5:2]));

    // R12: with no enable the status holds and nothing is written.
    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(status_o));

    a_r12_idle_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !wr_o);

    // R6 / R7: compare and bit test never write a result.
    a_r6_r7_flag_only: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd4 || op_i == 4'd5) |-> (!wr_o && result_o == 8'h00));

    // R11: the result bus is quiet whenever no write happens.
    a_r11_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_o |-> result_o == 8'h00);

    // R5: a shift clears N and moves the outgoing bit into C.
    a_r5_shift_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op_i == 4'd3) |=> (!status_o[7] && status_o[0] == $past(mem_i[0])));

    // R2: add carry matches the unbounded sum against 255.
    a_r2_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op_i == 4'd0) |=>
        status_o[0] == $past(({1'b0, reg_i} + {1'b0, mem_i} + {8'd0, status_o[0]}) > 9'd255));

    // R9: set carry leaves C high.
    a_r9_set_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op_i == 4'd9) |=> status_o[0]);

    // R10: unused op codes leave the status alone.
    a_r10_unused_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op_i >= 4'd11) |=> $stable(status_o));

endmodule

bind alu8_status alu8_status_sva u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .op_i     (op_i),
    .reg_i    (reg_i),
    .mem_i    (mem_i),
    .result_o (result_o),
    .wr_o     (wr_o),
    .status_o (status_o)
);

// File: tb/alu8_status_tb_top.sv
// Bench: directed corner cases plus seeded random operations, each compared
// against a reference model written from the requirements.
module alu8_status_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic [3:0] op_i = 4'd0;
    logic [7:0] reg_i = 8'd0;
    logic [7:0] mem_i = 8'd0;
    logic [7:0] result_o;
    logic       wr_o;
    logic [7:0] status_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_st;

    always #4 clk = ~clk;   // 125 MHz

    alu8_status dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .op_i(op_i),
        .reg_i(reg_i), .mem_i(mem_i),
        .result_o(result_o), .wr_o(wr_o), .status_o(status_o)
    );

    // Reference model: returns {wr, result, next status}.
    function automatic logic [16:0] model(input logic en, input logic [3:0] op,
                                          input logic [7:0] a, input logic [7:0] m,
                                          input logic [7:0] st);
        logic [7:0] ns, r, b;
        logic [8:0] s;
        logic w;
        ns = st; r = 8'd0; w = 1'b0;
        if (en) begin
            case (op)
                4'd0, 4'd1: begin
                    b = (op == 4'd1) ? ~m : m;
                    s = {1'b0, a} + {1'b0, b} + {8'd0, st[0]};
                    r = s[7:0]; w = 1'b1;
                    ns[0] = s[8];
                    ns[6] = (a[7] == b[7]) && (r[7] != a[7]);
                    ns[7] = r[7]; ns[1] = (r == 8'd0);
                end
                4'd2: begin r = a & m; w = 1'b1; ns[7] = r[7]; ns[1] = (r == 0); end
                4'd3: begin r = m >> 1; w = 1'b1; ns[0] = m[0]; ns[7] = 1'b0; ns[1] = (r == 0); end
                4'd4: begin
                    b = a - m;
                    ns[0] = (a >= m); ns[1] = (a == m); ns[7] = b[7];
                end
                4'd5: begin ns[1] = ((a & m) == 0); ns[6] = m[6]; ns[7] = m[7]; end
                4'd6, 4'd7, 4'd8: begin
                    r = (op == 4'd6) ? m + 8'd1 : (op == 4'd7) ? m - 8'd1 : m;
                    w = 1'b1; ns[7] = r[7]; ns[1] = (r == 0);
                end
                4'd9:  ns[0] = 1'b1;
                4'd10: ns[0] = 1'b0;
                default: ;
            endcase
        end
        return {w, r, ns};
    endfunction

    function automatic string req_of(input logic en, input logic [3:0] op);
        if (!en) return "R12";
        case (op)
            4'd0: return "R2";   4'd1: return "R3";   4'd2: return "R4";
            4'd3: return "R5";   4'd4: return "R6";   4'd5: return "R7";
            4'd6, 4'd7, 4'd8: return "R8";
            4'd9, 4'd10: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    // Apply one operation, check the same-cycle outputs, then the new status.
    task automatic do_op(input logic en, input logic [3:0] op,
                         input logic [7:0] a, input logic [7:0] m);
        logic [16:0] e;
        string rq;
        @(negedge clk);
        en_i = en; op_i = op; reg_i = a; mem_i = m;
        e = model(en, op, a, m, exp_st);
        rq = req_of(en, op);
        #1;
        check({rq, "/R11"}, "wr_o", {7'd0, wr_o}, {7'd0, e[16]});
        check({rq, "/R11"}, "result_o", result_o, e[15:8]);
        @(posedge clk);
        #1;
        exp_st = e[7:0];
        check({rq, "/R1"}, "status_o", status_o, exp_st);
        en_i = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; en_i = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        exp_st = 8'h20;
        check("R1", "status after reset", status_o, 8'h20);
        check("R12", "wr_o in reset", {7'd0, wr_o}, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed_ignore;
        seed_ignore = $urandom(32'd20240611);
        exp_st = 8'h20;
        do_reset();

        // R2: signed overflow at 0x7F + 1, carry clear.
        do_op(1, 4'd10, 8'h00, 8'h00);
        do_op(1, 4'd0, 8'h7F, 8'h01);
        check("R2", "overflow flags", status_o, 8'hE0);
        // R2: unsigned wrap 0xFF + 1.
        do_op(1, 4'd0, 8'hFF, 8'h01);
        check("R2", "carry wrap flags", status_o, 8'h23);
        // R3: 0x00 - 1 with no borrow in (C=1) -> 0xFF, borrow out.
        do_op(1, 4'd9, 8'h00, 8'h00);
        do_op(1, 4'd1, 8'h00, 8'h01);
        check("R3", "borrow flags", status_o, 8'hA0);
        // R3: 0x80 - 1 with C=1 -> 0x7F, V set.
        do_op(1, 4'd9, 8'h00, 8'h00);
        do_op(1, 4'd1, 8'h80, 8'h01);
        check("R3", "sub overflow", status_o, 8'h61);
        // R6: equal compare.
        do_op(1, 4'd4, 8'h42, 8'h42);
        check("R6", "equal compare", status_o, 8'h63);
        do_op(1, 4'd4, 8'h10, 8'h20);
        // R7: bit test with operand bits 7 and 6 set, no common bits.
        do_op(1, 4'd5, 8'h01, 8'hC0);
        // R5: shift of 0x01.
        do_op(1, 4'd3, 8'h00, 8'h01);
        // R8: increment and decrement wraps, transfer.
        do_op(1, 4'd6, 8'h00, 8'hFF);
        do_op(1, 4'd7, 8'h00, 8'h00);
        do_op(1, 4'd8, 8'h00, 8'h80);
        // R4: AND to zero.
        do_op(1, 4'd2, 8'hF0, 8'h0F);
        // R10, R12: unused ops and disabled ops.
        do_op(1, 4'd13, 8'hFF, 8'hFF);
        do_op(0, 4'd0, 8'hFF, 8'hFF);

        // Seeded random traffic with occasional idle cycles and one reset.
        for (int i = 0; i < 3000; i++) begin
            logic en_r;
            en_r = ($urandom % 8) != 0;
            do_op(en_r, 4'($urandom % 16), 8'($urandom), 8'($urandom));
            if (i == 1500) do_reset();
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule